// File: doc/BRIEF.md
# PS/2 Bus Monitor

This block is a passive observer for a two-wire PS/2 link. It samples the clock and data wires, which arrive asynchronously, on a faster system clock. It recovers every frame on the wire and works out whether the keyboard or mouse sent it to the host, or the host sent it to the device. It never drives either wire.

Each frame carries eleven bit positions:

| Index | Bit |
|---|---|
| 0 | start, always 0 |
| 1 to 8 | data, least significant bit first |
| 9 | odd parity |
| 10 | stop |

Frames from the host to the device carry one more slot, in which the device acknowledges. For every frame that completes, the block raises `res_valid` for exactly one system cycle. During that cycle it presents these fields:

- the data byte
- the direction
- the parity status
- a framing error flag
- an acknowledge flag

The result port has no ready signal and no back-pressure. The monitor cannot stall the bus it watches, so a consumer must take the fields in the cycle in which `res_valid` is high, or lose them. Frames follow each other at least several hundred system cycles apart, so a consumer running at the system clock always has time.

Top module: `ps2_bus_monitor`

## Requirements
- R1: After reset `res_valid` is low, and it stays low while the bus has no clock activity.
- R2: A falling clock edge seen in idle while data is low starts a device-to-host frame, and that sample is the start bit. Bits are then sampled on the falling edge by default. When the stop bit is sampled, a result with `res_dir`=0 and `res_ack`=0 is strobed, carrying data bits 1..8 with bit 1 as the LSB.
- R3: A falling clock edge seen in idle while data is high starts a host-to-device frame and is not taken as a bit. The start bit is the next rising clock edge at which data is low. The later bits are taken on rising edges by default, and the result has `res_dir`=1.
- R4: `res_parity_ok` is 1 exactly when the eight data bits together with bit 9 contain an odd number of ones.
- R5: `res_frame_err` is 1 exactly when bit 10 was sampled as 0.
- R6: After bit 10 of a host-to-device frame, data is sampled at the next falling clock edge. The result is strobed at the following rising clock edge, with `res_ack`=1 exactly when that sample was 0.
- R7: `cfg_h2d_on_fall`=1 moves host-to-device bits 1..10 to falling edges. `cfg_d2h_on_rise`=1 moves device-to-host bits 1..10 to rising edges.
- R8: This rule applies when device-to-host bits are sampled on falling edges. If data falls after the stop bit and before the next rising clock edge, the next frame is host-to-device, and its start bit is that next rising edge with data low. If the clock rises first, the monitor returns to idle.
- R9: The clock may stay high for more than `TIMEOUT_CYC` system cycles while a frame is in progress. In that case the monitor returns to idle with no strobe, and the next frame is decoded from its start.
- R10: `res_valid` is never high on two consecutive cycles, and each completed frame produces exactly one strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ps2_clk_i | input | 1 | PS/2 clock wire, asynchronous |
| ps2_data_i | input | 1 | PS/2 data wire, asynchronous |
| cfg_h2d_on_fall | input | 1 | 1 = sample host-to-device bits on falling edges |
| cfg_d2h_on_rise | input | 1 | 1 = sample device-to-host bits on rising edges |
| res_valid | output | 1 | One-cycle result strobe |
| res_byte | output | 8 | Received data byte |
| res_dir | output | 1 | 1 = host to device, 0 = device to host |
| res_parity_ok | output | 1 | Odd parity matched |
| res_frame_err | output | 1 | Stop bit was 0 |
| res_ack | output | 1 | Device acknowledged (host-to-device only) |

## Verification
The assertions take three things for granted:

- Clock and data never change in the same system cycle.
- Each half period of the PS/2 clock lasts well over three system cycles, so every edge survives the synchroniser as a separate event.
- The two configuration inputs change only while the bus is idle.

The stimulus changes data only in the middle of a clock phase and uses an eight-cycle half period. It switches the configuration only between frames, and the only long clock-high stretches it produces are those that deliberately exercise the timeout.

// File: rtl/ps2_mon_pkg.sv
package ps2_mon_pkg;

  localparam int FRAME_BITS = 11;
  localparam int IDX_W      = $clog2(FRAME_BITS);
  localparam int LAST_IDX   = FRAME_BITS - 1;
  localparam int BYTE_W     = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_H_REQ,
    ST_H_BITS,
    ST_ACK_FALL,
    ST_ACK_RISE,
    ST_D_BITS,
    ST_D_POST
  } mon_state_t;

  typedef struct packed {
    logic [BYTE_W-1:0] byte_v;
    logic              dir;
    logic              par_ok;
    logic              frame_err;
    logic              ack;
  } mon_result_t;

  function automatic logic odd_ok(input logic [BYTE_W:0] bits);
    return ^bits;
  endfunction

endpackage

// File: rtl/ps2_mon_sync.sv
module ps2_mon_sync #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] async_i,
  output logic [LINES-1:0] lvl_o,
  output logic [LINES-1:0] rise_o,
  output logic [LINES-1:0] fall_o
);

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-1:0], async_i[g]};
    end

    assign lvl_o[g]  = chain[STAGES-1];
    assign rise_o[g] = chain[STAGES-1] & ~chain[STAGES];
    assign fall_o[g] = ~chain[STAGES-1] & chain[STAGES];
  end

endmodule

// File: rtl/ps2_mon_idle.sv
module ps2_mon_idle #(
  parameter int TIMEOUT_CYC = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busy_i,
  input  logic clk_lvl_i,
  output logic expire_o
);

  localparam int CW = $clog2(TIMEOUT_CYC + 2);
  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT_CYC);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !busy_i || !clk_lvl_i) cnt <= '0;
    else if (cnt <= LIMIT)               cnt <= cnt + 1'b1;
  end

  assign expire_o = (cnt > LIMIT);

  AST_TMR_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LIMIT + 1'b1);  // R9

endmodule

// File: rtl/ps2_mon_frame.sv
module ps2_mon_frame
  import ps2_mon_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        c_lvl,
  input  logic        c_rise,
  input  logic        c_fall,
  input  logic        d_lvl,
  input  logic        d_fall,
  input  logic        h2d_on_fall,
  input  logic        d2h_on_rise,
  input  logic        expire_i,
  output logic        busy_o,
  output logic        res_valid_o,
  output mon_result_t res_o
);

  mon_state_t            state;
  logic [IDX_W-1:0]      idx;
  logic [FRAME_BITS-1:0] bits;
  logic                  ack_raw;
  logic                  h2d_edge;
  logic                  d2h_edge;
  logic                  at_last;

  assign h2d_edge = h2d_on_fall ? c_fall : c_rise;
  assign d2h_edge = d2h_on_rise ? c_rise : c_fall;
  assign at_last  = (idx == IDX_W'(LAST_IDX));
  assign busy_o   = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      idx         <= '0;
      bits        <= '0;
      ack_raw     <= 1'b1;
      res_valid_o <= 1'b0;
      res_o       <= '0;
    end else begin
      res_valid_o <= 1'b0;
      if (expire_i) begin
        state <= ST_IDLE;
        idx   <= '0;
      end else begin
        unique case (state)
          ST_IDLE: begin
            if (c_fall) begin
              if (d_lvl) begin
                state <= ST_H_REQ;
              end else begin
                bits[0] <= 1'b0;
                idx     <= IDX_W'(1);
                state   <= ST_D_BITS;
              end
            end
          end
          ST_H_REQ: begin
            if (c_rise && !d_lvl) begin
              bits[0] <= 1'b0;
              idx     <= IDX_W'(1);
              state   <= ST_H_BITS;
            end
          end
          ST_H_BITS: begin
            if (h2d_edge) begin
              bits[idx] <= d_lvl;
              if (at_last) state <= ST_ACK_FALL;
              else         idx   <= idx + 1'b1;
            end
          end
          ST_ACK_FALL: begin
            if (c_fall) begin
              ack_raw <= d_lvl;
              state   <= ST_ACK_RISE;
            end
          end
          ST_ACK_RISE: begin
            if (c_rise) begin
              res_valid_o     <= 1'b1;
              res_o.byte_v    <= bits[BYTE_W:1];
              res_o.dir       <= 1'b1;
              res_o.par_ok    <= odd_ok(bits[BYTE_W+1:1]);
              res_o.frame_err <= ~bits[LAST_IDX];
              res_o.ack       <= ~ack_raw;
              idx             <= '0;
              state           <= ST_IDLE;
            end
          end
          ST_D_BITS: begin
            if (d2h_edge) begin
              bits[idx] <= d_lvl;
              if (at_last) begin
                res_valid_o     <= 1'b1;
                res_o.byte_v    <= bits[BYTE_W:1];
                res_o.dir       <= 1'b0;
                res_o.par_ok    <= odd_ok(bits[BYTE_W+1:1]);
                res_o.frame_err <= ~d_lvl;
                res_o.ack       <= 1'b0;
                idx             <= '0;
                state           <= d2h_on_rise ? ST_IDLE : ST_D_POST;
              end else begin
                idx <= idx + 1'b1;
              end
            end
          end
          ST_D_POST: begin
            if (d_fall)      state <= ST_H_REQ;
            else if (c_rise) state <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o |=> !res_valid_o);  // R10
  AST_D2H_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && !res_o.dir) |-> !res_o.ack);  // R2
  AST_H2D_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && res_o.dir) |-> $past(c_rise));  // R6
  AST_TIMEOUT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    expire_i |=> (state == ST_IDLE) && !res_valid_o);  // R9
  AST_POST_ONLY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_D_POST && $past(state) == ST_D_BITS) |-> $past(c_fall));  // R8

endmodule

// File: rtl/ps2_bus_monitor.sv
module ps2_bus_monitor
  import ps2_mon_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int TIMEOUT_CYC = 4096
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ps2_clk_i,
  input  logic       ps2_data_i,
  input  logic       cfg_h2d_on_fall,
  input  logic       cfg_d2h_on_rise,
  output logic       res_valid,
  output logic [7:0] res_byte,
  output logic       res_dir,
  output logic       res_parity_ok,
  output logic       res_frame_err,
  output logic       res_ack
);

  localparam int LINES = 2;
  localparam int L_CLK = 0;
  localparam int L_DAT = 1;

  logic [LINES-1:0] lvl, rise, fall;
  logic             busy, expire;
  mon_result_t      res;

  ps2_mon_sync #(.LINES(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i({ps2_data_i, ps2_clk_i}),
    .lvl_o  (lvl),
    .rise_o (rise),
    .fall_o (fall)
  );

  ps2_mon_idle #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_idle (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy_i   (busy),
    .clk_lvl_i(lvl[L_CLK]),
    .expire_o (expire)
  );

  ps2_mon_frame u_frame (
    .clk        (clk),
    .rst_n      (rst_n),
    .c_lvl      (lvl[L_CLK]),
    .c_rise     (rise[L_CLK]),
    .c_fall     (fall[L_CLK]),
    .d_lvl      (lvl[L_DAT]),
    .d_fall     (fall[L_DAT]),
    .h2d_on_fall(cfg_h2d_on_fall),
    .d2h_on_rise(cfg_d2h_on_rise),
    .expire_i   (expire),
    .busy_o     (busy),
    .res_valid_o(res_valid),
    .res_o      (res)
  );

  assign res_byte      = res.byte_v;
  assign res_dir       = res.dir;
  assign res_parity_ok = res.par_ok;
  assign res_frame_err = res.frame_err;
  assign res_ack       = res.ack;

  wire unused_rise_dat = rise[L_DAT];

  AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(busy) |-> !res_valid);  // R1

endmodule

// File: tb/tb_ps2_bus_monitor.sv
module tb_ps2_bus_monitor;

  localparam int H  = 8;
  localparam int TO = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ps2c = 1'b1, ps2d = 1'b1;
  logic cfg_hf = 1'b0, cfg_dr = 1'b0;
  logic       res_valid, res_dir, res_parity_ok, res_frame_err, res_ack;
  logic [7:0] res_byte;

  int checks = 0;
  int errors = 0;
  int mon_err = 0;
  logic [11:0] q[$];
  logic prev_v = 1'b0;

  always #5 clk = ~clk;

  ps2_bus_monitor #(.TIMEOUT_CYC(TO)) dut (
    .clk(clk), .rst_n(rst_n), .ps2_clk_i(ps2c), .ps2_data_i(ps2d),
    .cfg_h2d_on_fall(cfg_hf), .cfg_d2h_on_rise(cfg_dr),
    .res_valid(res_valid), .res_byte(res_byte), .res_dir(res_dir),
    .res_parity_ok(res_parity_ok), .res_frame_err(res_frame_err), .res_ack(res_ack)
  );

  // strobe collector, every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (res_valid)
        q.push_back({res_byte, res_dir, res_parity_ok, res_frame_err, res_ack});
      if (res_valid && prev_v) begin
        mon_err++;
        $display("FAIL R10 strobe width: actual 2+ cycles expected 1");
      end
      prev_v <= res_valid;
    end
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [10:0] mkframe(input logic [7:0] b, input bit bad_par, input bit stop);
    int ones = 0;
    for (int i = 0; i < 8; i++) ones += b[i];
    return {stop, ((ones % 2) == 0) ^ bad_par, b, 1'b0};
  endfunction

  function automatic bit exp_par(input logic [7:0] b, input bit bad_par);
    return !bad_par;
  endfunction

  task automatic expect_res(input string tag, input logic [7:0] b, input bit dir,
                            input bit pok, input bit ferr, input bit ack);
    logic [11:0] r;
    if (q.size() == 0) begin
      chk({tag, " strobe present"}, 0, 1);
      return;
    end
    r = q.pop_front();
    chk({tag, " byte"}, r[11:4], b);
    chk({tag, " dir"}, r[3], dir);
    chk("R4 parity_ok", r[2], pok);
    chk("R5 frame_err", r[1], ferr);
    chk("R6 ack", r[0], ack);
  endtask

  task automatic expect_none(input string tag);
    chk({tag, " extra strobes"}, q.size(), 0);
    q.delete();
  endtask

  // device-to-host, bits sampled on falling edges
  task automatic d2h(input logic [7:0] b, input bit bad_par, input bit stop, input bit chain);
    logic [10:0] v = mkframe(b, bad_par, stop);
    for (int i = 0; i < 11; i++) begin
      ps2d = v[i]; wt(H);
      ps2c = 1'b0; wt(H);
      if (i == 10 && chain) begin ps2d = 1'b0; wt(H); end
      ps2c = 1'b1; wt(H);
    end
    if (!chain) ps2d = 1'b1;
  endtask

  // device-to-host, bits 1..10 sampled on rising edges
  task automatic d2h_rise(input logic [7:0] b);
    logic [10:0] v = mkframe(b, 1'b0, 1'b1);
    ps2d = 1'b0; wt(H);
    ps2c = 1'b0; wt(H/2);
    for (int i = 1; i < 11; i++) begin
      ps2d = v[i]; wt(H/2);
      ps2c = 1'b1; wt(H);
      if (i < 10) begin ps2c = 1'b0; wt(H/2); end
    end
    ps2d = 1'b1; wt(H);
  endtask

  // host-to-device frame plus acknowledge slot
  task automatic h2d(input logic [7:0] b, input bit bad_par, input bit stop,
                     input bit ackv, input bit skip_req);
    logic [10:0] v = mkframe(b, bad_par, stop);
    if (!skip_req) begin
      ps2c = 1'b0; wt(H);
      ps2d = 1'b0; wt(H);
      ps2c = 1'b1; wt(H);
    end
    for (int i = 1; i < 11; i++) begin
      if (!cfg_hf) begin
        ps2c = 1'b0; wt(H/2);
        ps2d = v[i]; wt(H/2);
        ps2c = 1'b1; wt(H);
      end else begin
        ps2d = v[i]; wt(H/2);
        ps2c = 1'b0; wt(H);
        ps2c = 1'b1; wt(H/2);
      end
    end
    ps2d = ackv; wt(H/2);
    ps2c = 1'b0; wt(H);
    ps2c = 1'b1; wt(H);
    ps2d = 1'b1; wt(H);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors + mon_err);
    $finish;
  end

  initial begin
    wt(4);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 res_valid after reset", res_valid, 0);
    wt(30);
    expect_none("R1 quiet bus");

    d2h(8'hA5, 1'b0, 1'b1, 1'b0); wt(10);
    expect_res("R2 d2h A5", 8'hA5, 0, 1, 0, 0);
    expect_none("R10 single strobe");

    d2h(8'h00, 1'b1, 1'b1, 1'b0); wt(10);
    expect_res("R4 d2h bad parity", 8'h00, 0, exp_par(8'h00, 1'b1), 0, 0);

    d2h(8'h81, 1'b0, 1'b0, 1'b0); wt(10);
    expect_res("R5 d2h stop low", 8'h81, 0, 1, 1, 0);

    h2d(8'hED, 1'b0, 1'b1, 1'b0, 1'b0); wt(10);
    expect_res("R3 h2d ED", 8'hED, 1, 1, 0, 1);
    expect_none("R10 single strobe h2d");

    h2d(8'h12, 1'b1, 1'b1, 1'b1, 1'b0); wt(10);
    expect_res("R6 h2d no ack", 8'h12, 1, 0, 0, 0);

    h2d(8'hF0, 1'b0, 1'b0, 1'b0, 1'b0); wt(10);
    expect_res("R5 h2d stop low", 8'hF0, 1, 1, 1, 1);

    cfg_dr = 1'b1; wt(4);
    d2h_rise(8'h5A); wt(10);
    expect_res("R7 d2h rising", 8'h5A, 0, 1, 0, 0);
    cfg_dr = 1'b0; cfg_hf = 1'b1; wt(4);
    h2d(8'hC3, 1'b0, 1'b1, 1'b0, 1'b0); wt(10);
    expect_res("R7 h2d falling", 8'hC3, 1, 1, 0, 1);
    cfg_hf = 1'b0; wt(4);

    d2h(8'h11, 1'b0, 1'b1, 1'b1);
    h2d(8'h77, 1'b0, 1'b1, 1'b0, 1'b1); wt(10);
    expect_res("R8 chained d2h", 8'h11, 0, 1, 0, 0);
    expect_res("R8 forced h2d", 8'h77, 1, 1, 0, 1);
    expect_none("R8 chain count");

    // partial device frame, then a long clock-high stall
    begin
      logic [10:0] v = mkframe(8'hFF, 1'b0, 1'b1);
      for (int i = 0; i < 4; i++) begin
        ps2d = v[i]; wt(H);
        ps2c = 1'b0; wt(H);
        ps2c = 1'b1; wt(H);
      end
      ps2d = 1'b1; wt(TO + 40);
    end
    expect_none("R9 no strobe on stall");
    d2h(8'h3C, 1'b0, 1'b1, 1'b0); wt(10);
    expect_res("R9 after stall", 8'h3C, 0, 1, 0, 0);

    // host request edge with no start bit, then a stall
    ps2c = 1'b0; wt(H);
    ps2c = 1'b1; wt(TO + 40);
    expect_none("R9 request stall");
    d2h(8'h66, 1'b0, 1'b1, 1'b0); wt(10);
    expect_res("R9 d2h after request stall", 8'h66, 0, 1, 0, 0);
    expect_none("R10 final");

    $display("CHECKS %0d ERRORS %0d", checks, errors + mon_err);
    $finish;
  end

endmodule